// File: doc/BRIEF.md
# Port-Shared Input Debounce Filter

This block sits between the synchronized pad inputs of one 32-pin bank and the logic that consumes them: the input register and the interrupt edge/level detector both see its filtered output. The bank is split into ports of eight pins. Every port owns one 8-bit period, counted in ticks of an externally supplied one-millisecond strobe. Each pin owns an enable bit.

A pin with its enable clear, or whose port period is zero, is passed through combinationally. An enabled pin with a non-zero period moves its output to a new level only after the raw input has held that level for the port's period of consecutive ticks. Each pin has its own tick counter. Any change of the raw input restarts that counter, and so does a return to the current filtered level. Software programs periods with plain writes and enables with masked writes, so one pin can be changed without a read-modify-write.

A build parameter removes the filter. Without it, every pin passes straight through and every register reads as zero.

Top module: `dbc_bank_top`

## Requirements
- R1: While reset is asserted and directly after it, every filtered output equals its raw input and every register reads as zero.
- R2: A pin whose enable bit is 0 drives its raw input onto its output in the same cycle.
- R3: For an enabled pin with port period P>0, a new raw level that is first sampled at clock edge e0 appears on the output after the P-th tick that is sampled at a later edge, with no raw change in between. The output is registered at that edge.
- R4: If the raw input changes before P qualifying ticks have been seen, the count restarts. A pulse shorter than P ticks leaves the output unchanged.
- R5: An enabled pin on a port whose period is 0 behaves as pass-through.
- R6: All eight pins of a port use that port's period. Ports filter independently, each with its own period.
- R7: A write to an enable register takes wr_data_i[15:8] as a bit mask and wr_data_i[7:0] as new values. Only the pins whose mask bit is 1 change their enable.
- R8: Address bit 2 selects the register kind (0 = period, 1 = enable) and bits 1:0 select the port. rd_data_o returns the addressed register combinationally, and a period write stores wr_data_i[7:0].
- R9: With DEBOUNCE_ON=0 every output equals its raw input and rd_data_o is always zero, whatever is written.
- R10: An enabled pin with a non-zero period never changes its filtered output at an edge where tick_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle millisecond strobe |
| pin_i | input | 32 | Synchronized raw pad inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address {kind, port} |
| wr_data_i | input | 16 | Write data; for enable writes {mask, value} |
| rd_addr_i | input | 3 | Read address {kind, port} |
| rd_data_o | output | 8 | Read data of the addressed register |
| pin_o | output | 32 | Filtered pin values |

## Verification
Two events can coincide in one cycle: a register write (a period change, or a masked enable change) and a filter step (a raw transition, or a tick that completes a count). The random phase drives writes, ticks and raw flips independently every cycle, so all of them frequently land on the same edge. The bench model advances the filters with the register values from before the edge and applies the write afterwards, and it compares the 32 outputs and the read data against the design every cycle.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int unsigned DBC_PORTS = 4;
  localparam int unsigned DBC_PINS  = 8;
  localparam int unsigned DBC_CNT_W = 8;

  typedef enum logic {
    REG_PERIOD = 1'b0,
    REG_ENABLE = 1'b1
  } dbc_reg_e;
endpackage

// File: rtl/dbc_pin_filter.sv
module dbc_pin_filter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             filt_o,
  output logic             pin_o
);
  logic             bypass;
  logic             last_q;
  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;

  assign bypass  = !en_i || (period_i == '0);
  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (bypass) begin
      // track raw so enabling starts from a settled state
      last_q <= raw_i;
      filt_q <= raw_i;
      cnt_q  <= '0;
    end else if (raw_i != last_q) begin
      last_q <= raw_i;
      cnt_q  <= '0;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_nxt >= {1'b0, period_i}) begin
        filt_q <= raw_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_nxt[CNT_W-1:0];
      end
    end
  end

  assign filt_o = filt_q;
  assign pin_o  = bypass ? raw_i : filt_q;
endmodule

// File: rtl/dbc_port.sv
module dbc_port #(
  parameter int unsigned PINS  = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [PINS-1:0]  raw_i,
  input  logic [PINS-1:0]  en_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [PINS-1:0]  pin_o,
  output logic [PINS-1:0]  filt_o,
  output logic [PINS-1:0]  active_o
);
  assign active_o = en_i & {PINS{period_i != '0}};

  for (genvar b = 0; b < PINS; b++) begin : g_pin
    dbc_pin_filter #(.CNT_W(CNT_W)) u_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .raw_i   (raw_i[b]),
      .tick_i  (tick_i),
      .en_i    (en_i[b]),
      .period_i(period_i),
      .filt_o  (filt_o[b]),
      .pin_o   (pin_o[b])
    );
  end
endmodule

// File: rtl/dbc_regs.sv
module dbc_regs
  import dbc_pkg::*;
#(
  parameter int unsigned PORTS  = 4,
  parameter int unsigned PINS   = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RD_W   = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [RD_W-1:0]        rd_data_o,
  output logic [PORTS*PINS-1:0]  en_flat_o,
  output logic [PORTS*CNT_W-1:0] period_flat_o
);
  logic [CNT_W-1:0] period_q [PORTS];
  logic [PINS-1:0]  en_q     [PORTS];

  dbc_reg_e         wr_kind, rd_kind;
  logic [SEL_W-1:0] wr_port, rd_port;
  logic [PINS-1:0]  wr_mask, wr_val;

  assign wr_kind = dbc_reg_e'(wr_addr_i[ADDR_W-1]);
  assign rd_kind = dbc_reg_e'(rd_addr_i[ADDR_W-1]);
  assign wr_port = wr_addr_i[SEL_W-1:0];
  assign rd_port = rd_addr_i[SEL_W-1:0];
  assign wr_val  = wr_data_i[PINS-1:0];
  assign wr_mask = wr_data_i[2*PINS-1:PINS];

  for (genvar p = 0; p < PORTS; p++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        period_q[p] <= '0;
        en_q[p]     <= '0;
      end else if (wr_en_i && wr_port == SEL_W'(p)) begin
        if (wr_kind == REG_ENABLE) en_q[p] <= (en_q[p] & ~wr_mask) | (wr_val & wr_mask);
        else                       period_q[p] <= wr_data_i[CNT_W-1:0];
      end
    end
    assign en_flat_o[p*PINS +: PINS]       = en_q[p];
    assign period_flat_o[p*CNT_W +: CNT_W] = period_q[p];
  end

  always_comb begin
    if (rd_kind == REG_ENABLE) rd_data_o = RD_W'(en_q[rd_port]);
    else                       rd_data_o = RD_W'(period_q[rd_port]);
  end
endmodule

// File: rtl/dbc_bank_top.sv
module dbc_bank_top
  import dbc_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = DBC_PORTS,
  parameter int unsigned PORT_PINS   = DBC_PINS,
  parameter int unsigned CNT_W       = DBC_CNT_W,
  parameter bit          DEBOUNCE_ON = 1'b1,
  localparam int unsigned NPIN   = NUM_PORTS * PORT_PINS,
  localparam int unsigned SEL_W  = $clog2(NUM_PORTS),
  localparam int unsigned ADDR_W = SEL_W + 1,
  localparam int unsigned DATA_W = 2 * PORT_PINS,
  localparam int unsigned RD_W   = (PORT_PINS >= CNT_W) ? PORT_PINS : CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [RD_W-1:0]   rd_data_o,
  output logic [NPIN-1:0]   pin_o
);
  logic [NPIN-1:0] en_flat;
  logic [NPIN-1:0] active_w;
  logic [NPIN-1:0] filt_w;

  if (DEBOUNCE_ON) begin : g_dbc
    logic [NUM_PORTS*CNT_W-1:0] period_flat;

    dbc_regs #(
      .PORTS(NUM_PORTS), .PINS(PORT_PINS), .CNT_W(CNT_W),
      .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_W(RD_W)
    ) u_regs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_en_i      (wr_en_i),
      .wr_addr_i    (wr_addr_i),
      .wr_data_i    (wr_data_i),
      .rd_addr_i    (rd_addr_i),
      .rd_data_o    (rd_data_o),
      .en_flat_o    (en_flat),
      .period_flat_o(period_flat)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      dbc_port #(.PINS(PORT_PINS), .CNT_W(CNT_W)) u_port (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .raw_i   (pin_i[p*PORT_PINS +: PORT_PINS]),
        .en_i    (en_flat[p*PORT_PINS +: PORT_PINS]),
        .period_i(period_flat[p*CNT_W +: CNT_W]),
        .pin_o   (pin_o[p*PORT_PINS +: PORT_PINS]),
        .filt_o  (filt_w[p*PORT_PINS +: PORT_PINS]),
        .active_o(active_w[p*PORT_PINS +: PORT_PINS])
      );
    end
  end else begin : g_bypass
    assign en_flat   = '0;
    assign active_w  = '0;
    assign filt_w    = pin_i;
    assign pin_o     = pin_i;
    assign rd_data_o = '0;
  end
endmodule

// File: rtl/dbc_bank_chk.sv
module dbc_bank_chk #(
  parameter int unsigned PORTS  = 4,
  parameter int unsigned PINS   = 8,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RD_W   = 8,
  parameter bit          ON     = 1'b1,
  localparam int unsigned NPIN  = PORTS * PINS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [NPIN-1:0]   pin_i,
  input logic [NPIN-1:0]   pin_o,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [RD_W-1:0]   rd_data_i,
  input logic [NPIN-1:0]   en_i,
  input logic [NPIN-1:0]   active_i,
  input logic [NPIN-1:0]   filt_i
);
  AST_BYPASS_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o ^ pin_i) & ~active_i) == '0); // R2

  AST_NO_CHANGE_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ((filt_i ^ $past(filt_i)) & $past(active_i)) == '0); // R10

  AST_CHANGE_TAKES_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((filt_i ^ $past(filt_i)) & $past(active_i) & (filt_i ^ $past(pin_i))) == '0); // R3

  for (genvar p = 0; p < PORTS; p++) begin : g_mask
    AST_MASK_KEEPS_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == {1'b1, SEL_W'(p)}) |=>
      ((en_i[p*PINS +: PINS] ^ $past(en_i[p*PINS +: PINS])) & ~$past(wr_data_i[PINS +: PINS])) == '0); // R7
  end

  if (!ON) begin : g_off
    AST_OFF_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_i == '0); // R9
  end
endmodule

bind dbc_bank_top dbc_bank_chk #(
  .PORTS(NUM_PORTS), .PINS(PORT_PINS), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .RD_W(RD_W), .ON(DEBOUNCE_ON)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .pin_i    (pin_i),
  .pin_o    (pin_o),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .rd_data_i(rd_data_o),
  .en_i     (en_flat),
  .active_i (active_w),
  .filt_i   (filt_w)
);

// File: tb/tb_dbc_bank_top.sv
module tb_dbc_bank_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_s = 1'b0;
  logic [31:0] raw_s = '0;
  logic        we_s = 1'b0;
  logic [2:0]  wa_s = '0;
  logic [15:0] wd_s = '0;
  logic [2:0]  ra_s = '0;
  logic [7:0]  dut_rd, off_rd;
  logic [31:0] dut_pin, off_pin;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbc_bank_top dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_s), .pin_i(raw_s),
    .wr_en_i(we_s), .wr_addr_i(wa_s), .wr_data_i(wd_s),
    .rd_addr_i(ra_s), .rd_data_o(dut_rd), .pin_o(dut_pin)
  );

  dbc_bank_top #(.DEBOUNCE_ON(1'b0)) dut_off (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_s), .pin_i(raw_s),
    .wr_en_i(we_s), .wr_addr_i(wa_s), .wr_data_i(wd_s),
    .rd_addr_i(ra_s), .rd_data_o(off_rd), .pin_o(off_pin)
  );

  // reference model built from the requirements
  logic       m_last [32];
  logic       m_filt [32];
  int         m_cnt  [32];
  logic [7:0] m_per  [4];
  logic [7:0] m_en   [4];

  function automatic logic m_byp(int i);
    return !m_en[i/8][i%8] || (m_per[i/8] == 8'd0);
  endfunction

  function automatic logic [31:0] exp_pins(logic [31:0] raw);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = m_byp(i) ? raw[i] : m_filt[i];
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    return a[2] ? m_en[a[1:0]] : m_per[a[1:0]];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin
        m_last[i] = 1'b0; m_filt[i] = 1'b0; m_cnt[i] = 0;
      end
      for (int p = 0; p < 4; p++) begin
        m_per[p] = '0; m_en[p] = '0;
      end
    end else begin
      for (int i = 0; i < 32; i++) begin
        if (m_byp(i)) begin
          m_last[i] = raw_s[i]; m_filt[i] = raw_s[i]; m_cnt[i] = 0;
        end else if (raw_s[i] != m_last[i]) begin
          m_last[i] = raw_s[i]; m_cnt[i] = 0;
        end else if (raw_s[i] == m_filt[i]) begin
          m_cnt[i] = 0;
        end else if (tick_s) begin
          if (m_cnt[i] + 1 >= int'(m_per[i/8])) begin
            m_filt[i] = raw_s[i]; m_cnt[i] = 0;
          end else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (we_s) begin
        if (wa_s[2]) m_en[wa_s[1:0]] = (m_en[wa_s[1:0]] & ~wd_s[15:8]) | (wd_s[7:0] & wd_s[15:8]);
        else         m_per[wa_s[1:0]] = wd_s[7:0];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] raw, input logic tk, input logic we,
                       input logic [2:0] wa, input logic [15:0] wd,
                       input logic [2:0] ra, input string tag);
    @(negedge clk);
    raw_s = raw; tick_s = tk; we_s = we; wa_s = wa; wd_s = wd; ra_s = ra;
    #1;
    chk(dut_pin === exp_pins(raw), tag, dut_pin, exp_pins(raw));
    chk(dut_rd === exp_rd(ra), "R8", {24'd0, dut_rd}, {24'd0, exp_rd(ra)});
    chk(off_pin === raw && off_rd === 8'd0, "R9", off_pin ^ {24'd0, off_rd}, raw);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    drive(raw_s, 1'b0, 1'b1, a, d, a, "R8");
  endtask

  task automatic step(input logic [31:0] raw, input logic tk, input string tag);
    drive(raw, tk, 1'b0, 3'd0, 16'd0, ra_s, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    // R1: reset state
    @(negedge clk); raw_s = 32'h5A3C_96E1; #1;
    chk(dut_pin === raw_s, "R1", dut_pin, raw_s);
    for (int a = 0; a < 8; a++) begin
      ra_s = 3'(a); #1;
      chk(dut_rd === 8'd0, "R1", {24'd0, dut_rd}, 32'd0);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(32'h0F0F_00FF, 1'b1, "R1");
    step(32'h0, 1'b1, "R2");

    // R8 period write and read back
    wr(3'b001, 16'h00A5);
    step(32'h0, 1'b0, "R8");
    ra_s = 3'b001; #1; chk(dut_rd === 8'hA5, "R8", {24'd0, dut_rd}, 32'hA5);

    // R7 masked enable writes on port 0
    wr(3'b100, 16'hF0FF);
    wr(3'b100, 16'h0F05);
    wr(3'b100, 16'h00FF);
    step(32'h0, 1'b0, "R7");
    ra_s = 3'b100; #1; chk(dut_rd === 8'hF5, "R7", {24'd0, dut_rd}, 32'hF5);
    wr(3'b100, 16'hFF10);

    // R3 exact latency, period 3, pin 4
    wr(3'b000, 16'h0003);
    step(32'h10, 1'b1, "R3"); chk(dut_pin[4] === 1'b0, "R3", {31'd0, dut_pin[4]}, 0);
    for (int k = 0; k < 3; k++) begin
      step(32'h10, 1'b1, "R3"); chk(dut_pin[4] === 1'b0, "R3", {31'd0, dut_pin[4]}, 0);
    end
    step(32'h10, 1'b1, "R3"); chk(dut_pin[4] === 1'b1, "R3", {31'd0, dut_pin[4]}, 1);
    // R2: disabled pin 0 follows raw at once
    step(32'h11, 1'b0, "R2"); chk(dut_pin[0] === 1'b1, "R2", {31'd0, dut_pin[0]}, 1);

    // R4 glitch on pin 5 shorter than the period
    wr(3'b100, 16'h2020);
    step(32'h30, 1'b1, "R4");
    step(32'h30, 1'b1, "R4");
    for (int k = 0; k < 6; k++) step(32'h10, 1'b1, "R4");
    chk(dut_pin[5] === 1'b0, "R4", {31'd0, dut_pin[5]}, 0);

    // R10 no ticks: pin 4 holds its old level
    for (int k = 0; k < 20; k++) step(32'h0, 1'b0, "R10");
    chk(dut_pin[4] === 1'b1, "R10", {31'd0, dut_pin[4]}, 1);
    for (int k = 0; k < 5; k++) step(32'h0, 1'b1, "R10");
    chk(dut_pin[4] === 1'b0, "R10", {31'd0, dut_pin[4]}, 0);

    // R5 zero period with enables set
    wr(3'b110, 16'hFFFF);
    wr(3'b010, 16'h0000);
    step(32'h00A5_0000, 1'b0, "R5");
    chk(dut_pin[23:16] === 8'hA5, "R5", {24'd0, dut_pin[23:16]}, 32'hA5);

    // R6 shared period per port: port0=2, port1=6
    wr(3'b100, 16'hFF00);
    wr(3'b101, 16'hFF00);
    step(32'h0, 1'b0, "R6");
    wr(3'b000, 16'h0002);
    wr(3'b001, 16'h0006);
    wr(3'b100, 16'hFFFF);
    wr(3'b101, 16'hFFFF);
    step(32'h0000_FFFF, 1'b1, "R6");
    for (int k = 0; k < 3; k++) step(32'h0000_FFFF, 1'b1, "R6");
    chk(dut_pin[15:0] === 16'h00FF, "R6", {16'd0, dut_pin[15:0]}, 32'h00FF);
    for (int k = 0; k < 4; k++) step(32'h0000_FFFF, 1'b1, "R6");
    chk(dut_pin[15:0] === 16'hFFFF, "R6", {16'd0, dut_pin[15:0]}, 32'hFFFF);

    // random phase: writes, ticks and raw flips on shared edges
    r = raw_s;
    for (int n = 0; n < 4000; n++) begin
      logic        we;
      logic [2:0]  wa;
      logic [15:0] wd;
      r  = r ^ ($urandom & $urandom & $urandom & $urandom);
      we = ($urandom % 6) == 0;
      wa = 3'($urandom);
      if (wa[2]) wd = 16'($urandom);
      else       wd = (($urandom % 16) == 0) ? 16'h00FF : 16'($urandom % 5);
      drive(r, 1'($urandom), we, wa, wd, 3'($urandom), "R3");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule